// File: doc/BRIEF.md
# DMA Channel Service Scheduler

This block picks which channel of a four-channel DMA controller is serviced next, hands that channel to a transfer unit, and records how far the transfer got. A channel is eligible when its request line has been captured high and its mask bit is clear. While the controller-disable command bit is high, no new channel is started. The scan is either fixed, with the lowest index first, or rotating, where the channel served last drops to the lowest priority.

A grant presents the channel's current position and its full transfer length, which is the base count plus one. In word mode both values are doubled. The transfer unit answers with a done pulse and a progress figure in the same scaled units. The block halves that figure in word mode and stores it as the channel's current count. When the stored count equals base plus one, the channel's terminal-count flag is set. A channel in cascade style never sets this flag.

The controller moves through three named states. SCAN picks a channel: the transition SCAN→GRANT happens when the controller is enabled and a channel is eligible, and SCAN→SCAN happens otherwise. GRANT holds the grant: GRANT→COMMIT happens on done, and GRANT→GRANT happens while waiting. COMMIT writes the count and flag and updates the rotation pointer, then always takes COMMIT→SCAN.

Top module: `dma_svc_sched`

## Requirements
- R1: After reset there is no grant, every terminal-count flag is 0, every current count is 0, and the rotation pointer sits on the highest channel, so the first rotating scan starts at channel 0.
- R2: Each request line is captured into a request-status bit every clock. Only channels with that bit set and their mask bit clear are granted. A masked or idle channel is never granted.
- R3: While `ctrl_disable` is 1, no new grant starts. A grant starts once it returns to 0.
- R4: With `rot_prio` = 0, among several eligible channels the lowest index is granted first.
- R5: With `rot_prio` = 1, the scan starts at the channel after the one last committed, wrapping around. Three held requests on channels 0, 1 and 2 are served in the order 0, 1, 2, 0.
- R6: During a grant, `gnt_len` equals (base+1) shifted left by `word_mode`, and `gnt_start` equals the channel's current count shifted left by `word_mode`.
- R7: Exactly one channel is granted at a time. The grant and its channel number hold, whatever the requests and masks do, until `xfer_done` is sampled high.
- R8: On commit, the progress value is shifted right by `word_mode` and stored as the channel's current count. This applies even when the value is lower than the start value, as happens with an auto-initialize restart.
- R9: A channel's terminal-count flag is set when its stored count equals base+1. It stays set until it is cleared.
- R10: A channel whose mode style bits [5:4] equal 3 (cascade) never sets its terminal-count flag.
- R11: The mode type field [1:0] decodes as 0 verify, 1 write, 2 read and 3 illegal. `gnt_mem_wr` is high only for write and `gnt_mem_rd` only for read, so verify and illegal raise neither. Bit 2 drives `gnt_autoinit` and bit 3 drives `gnt_down`.
- R12: A pulse on `tc_clr[i]` clears flag i and leaves the others untouched. A pulse on `ch_load[i]` sets channel i's current count to 0, and this takes priority over a commit to that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1 = two-byte units (counts doubled toward the transfer unit) |
| ctrl_disable | input | 1 | Command bit: stop starting grants |
| rot_prio | input | 1 | Command bit: rotating priority |
| dreq | input | N_CH | Per-channel request levels |
| mask | input | N_CH | Per-channel mask, 1 = blocked |
| tc_clr | input | N_CH | Clear terminal-count flags |
| ch_load | input | N_CH | Reset current count to zero |
| mode_flat | input | N_CH*6 | Per channel: [1:0] type, [2] auto-init, [3] down, [5:4] style |
| base_flat | input | N_CH*CNT_W | Per-channel base count |
| xfer_done | input | 1 | Transfer unit finished the granted step |
| xfer_progress | input | CNT_W+2 | Scaled count reached by the transfer unit |
| gnt_valid | output | 1 | A channel is granted |
| gnt_ch | output | log2(N_CH) | Granted channel |
| gnt_start | output | CNT_W+2 | Scaled start position |
| gnt_len | output | CNT_W+2 | Scaled full length |
| gnt_mem_wr | output | 1 | Granted transfer writes memory |
| gnt_mem_rd | output | 1 | Granted transfer reads memory |
| gnt_autoinit | output | 1 | Auto-initialize flag of granted channel |
| gnt_down | output | 1 | Address-decrement flag of granted channel |
| tc_status | output | N_CH | Terminal-count flags |
| cur_count_flat | output | N_CH*(CNT_W+1) | Per-channel current counts |

## Verification
The scheduler is tested with four request patterns:
- A single lone request, which shows that eligibility and the length and start arithmetic work at all.
- Two simultaneous requests with fixed priority, which separate ascending order from arrival order.
- Three held requests under rotation, where the order 0, 1, 2, 0 rules out both fixed order and a pointer that never advances.
- Requests held back by mask or disable, which show that blocking is honoured and that the grant appears once the block is lifted.

Progress values are chosen to cover several cases:
- A partial count.
- A count exactly equal to base+1.
- A count that drops below the start value.
- A word-mode count.
- A cascade-style channel that reaches base+1.

Together these distinguish the comparison that sets the flag from the style check that suppresses it. One grant is held for several cycles while its request drops, to show that nothing but done ends a grant.

// File: rtl/dma_svc_sched_pkg.sv
package dma_svc_sched_pkg;

    typedef enum logic [1:0] {
        ST_SCAN   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_COMMIT = 2'd2
    } sched_state_e;

    localparam int MODE_W = 6;

    localparam logic [1:0] XT_VERIFY  = 2'd0;
    localparam logic [1:0] XT_WRITE   = 2'd1;
    localparam logic [1:0] XT_READ    = 2'd2;
    localparam logic [1:0] STYLE_CASC = 2'd3;

endpackage

// File: rtl/dma_req_stage.sv
module dma_req_stage #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] dreq,
    input  logic [N_CH-1:0] mask,
    output logic [N_CH-1:0] eligible
);
    logic [N_CH-1:0] req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= dreq;
        end
    end

    assign eligible = req_q & ~mask;
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N_CH = 4,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] eligible,
    input  logic            rot_en,
    input  logic [CH_W-1:0] last_ch,
    output logic            any,
    output logic [CH_W-1:0] pick
);
    logic [CH_W-1:0] first_idx;
    logic [CH_W-1:0] probe;

    always_comb begin
        any       = 1'b0;
        pick      = '0;
        probe     = '0;
        first_idx = rot_en ? CH_W'(last_ch + 1'b1) : '0;
        for (int k = 0; k < N_CH; k++) begin
            probe = CH_W'(first_idx + CH_W'(k));
            if (!any && eligible[probe]) begin
                any  = 1'b1;
                pick = probe;
            end
        end
    end
endmodule

// File: rtl/dma_chan_track.sv
module dma_chan_track #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CUR_W = CNT_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_en,
    input  logic [CH_W-1:0]       commit_ch,
    input  logic [CUR_W-1:0]      commit_cnt,
    input  logic [N_CH*CNT_W-1:0] base_flat,
    input  logic [N_CH-1:0]       casc,
    input  logic [N_CH-1:0]       tc_clr,
    input  logic [N_CH-1:0]       ch_load,
    output logic [N_CH*CUR_W-1:0] cur_count_flat,
    output logic [N_CH-1:0]       tc_status
);
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [CUR_W-1:0] cnt_q;
        logic             tc_q;
        logic [CUR_W-1:0] end_mark;
        logic             sel;
        logic             hit;

        assign end_mark = {1'b0, base_flat[g*CNT_W +: CNT_W]} + CUR_W'(1);
        assign sel      = commit_en && (commit_ch == CH_W'(g)) && !ch_load[g];
        assign hit      = sel && (commit_cnt == end_mark) && !casc[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                tc_q  <= 1'b0;
            end else begin
                if (ch_load[g]) begin
                    cnt_q <= '0;
                end else if (sel) begin
                    cnt_q <= commit_cnt;
                end
                tc_q <= hit | (tc_q & ~tc_clr[g]);
            end
        end

        assign cur_count_flat[g*CUR_W +: CUR_W] = cnt_q;
        assign tc_status[g] = tc_q;
    end
endmodule

// File: rtl/dma_svc_sched.sv
module dma_svc_sched
    import dma_svc_sched_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CUR_W = CNT_W + 1,
    localparam int XW    = CNT_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_mode,
    input  logic                   ctrl_disable,
    input  logic                   rot_prio,
    input  logic [N_CH-1:0]        dreq,
    input  logic [N_CH-1:0]        mask,
    input  logic [N_CH-1:0]        tc_clr,
    input  logic [N_CH-1:0]        ch_load,
    input  logic [N_CH*MODE_W-1:0] mode_flat,
    input  logic [N_CH*CNT_W-1:0]  base_flat,
    input  logic                   xfer_done,
    input  logic [XW-1:0]          xfer_progress,
    output logic                   gnt_valid,
    output logic [CH_W-1:0]        gnt_ch,
    output logic [XW-1:0]          gnt_start,
    output logic [XW-1:0]          gnt_len,
    output logic                   gnt_mem_wr,
    output logic                   gnt_mem_rd,
    output logic                   gnt_autoinit,
    output logic                   gnt_down,
    output logic [N_CH-1:0]        tc_status,
    output logic [N_CH*CUR_W-1:0]  cur_count_flat
);
    sched_state_e    state_q, state_d;
    logic [N_CH-1:0] eligible;
    logic            pick_any;
    logic [CH_W-1:0] pick_ch;
    logic [CH_W-1:0] gnt_ch_q;
    logic [CH_W-1:0] last_ch_q;
    logic [XW-1:0]   prog_q;
    logic [CUR_W-1:0] commit_cnt;
    logic            commit_en;

    logic [MODE_W-1:0] mode_arr [N_CH];
    logic [CNT_W-1:0]  base_arr [N_CH];
    logic [CUR_W-1:0]  cur_arr  [N_CH];
    logic [N_CH-1:0]   casc;

    for (genvar g = 0; g < N_CH; g++) begin : g_unpack
        assign mode_arr[g] = mode_flat[g*MODE_W +: MODE_W];
        assign base_arr[g] = base_flat[g*CNT_W +: CNT_W];
        assign cur_arr[g]  = cur_count_flat[g*CUR_W +: CUR_W];
        assign casc[g]     = (mode_flat[g*MODE_W+4 +: 2] == STYLE_CASC);
    end

    dma_req_stage #(.N_CH(N_CH)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .dreq     (dreq),
        .mask     (mask),
        .eligible (eligible)
    );

    dma_prio_pick #(.N_CH(N_CH)) u_pick (
        .eligible (eligible),
        .rot_en   (rot_prio),
        .last_ch  (last_ch_q),
        .any      (pick_any),
        .pick     (pick_ch)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:   if (!ctrl_disable && pick_any) state_d = ST_GRANT;
            ST_GRANT:  if (xfer_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_SCAN;
            default:   state_d = ST_SCAN;
        endcase
    end

    // Per-state data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_ch_q  <= '0;
            last_ch_q <= CH_W'(N_CH - 1);
            prog_q    <= '0;
        end else begin
            unique case (state_q)
                ST_SCAN:   if (!ctrl_disable && pick_any) gnt_ch_q <= pick_ch;
                ST_GRANT:  if (xfer_done) prog_q <= xfer_progress;
                ST_COMMIT: last_ch_q <= gnt_ch_q;
                default:   ;
            endcase
        end
    end

    assign commit_en  = (state_q == ST_COMMIT);
    assign commit_cnt = word_mode ? prog_q[CNT_W+1:1] : prog_q[CNT_W:0];

    dma_chan_track #(.N_CH(N_CH), .CNT_W(CNT_W)) u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit_en      (commit_en),
        .commit_ch      (gnt_ch_q),
        .commit_cnt     (commit_cnt),
        .base_flat      (base_flat),
        .casc           (casc),
        .tc_clr         (tc_clr),
        .ch_load        (ch_load),
        .cur_count_flat (cur_count_flat),
        .tc_status      (tc_status)
    );

    // Outputs
    always_comb begin
        logic [MODE_W-1:0] m;
        m            = mode_arr[gnt_ch_q];
        gnt_valid    = (state_q == ST_GRANT);
        gnt_ch       = gnt_ch_q;
        gnt_start    = XW'(cur_arr[gnt_ch_q]) << word_mode;
        gnt_len      = (XW'(base_arr[gnt_ch_q]) + XW'(1)) << word_mode;
        gnt_mem_wr   = gnt_valid && (m[1:0] == XT_WRITE);
        gnt_mem_rd   = gnt_valid && (m[1:0] == XT_READ);
        gnt_autoinit = gnt_valid && m[2];
        gnt_down     = gnt_valid && m[3];
    end
endmodule

// File: rtl/dma_svc_sched_chk.sv
module dma_svc_sched_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16,
    localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CUR_W = CNT_W + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_disable,
    input logic [N_CH-1:0]       dreq,
    input logic [N_CH-1:0]       mask,
    input logic                  xfer_done,
    input logic                  gnt_valid,
    input logic [CH_W-1:0]       gnt_ch,
    input logic [N_CH*CNT_W-1:0] base_flat,
    input logic [N_CH-1:0]       tc_status,
    input logic [N_CH*CUR_W-1:0] cur_count_flat
);
    logic [N_CH-1:0] dreq_d1, dreq_d2, mask_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_d1 <= '0;
            dreq_d2 <= '0;
            mask_d  <= '0;
        end else begin
            dreq_d1 <= dreq;
            dreq_d2 <= dreq_d1;
            mask_d  <= mask;
        end
    end

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_valid) |-> (dreq_d2[gnt_ch] && !mask_d[gnt_ch]));

    assert_disable_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && ctrl_disable) |=> !gnt_valid);

    assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_ch)));

    for (genvar g = 0; g < N_CH; g++) begin : g_tc
        assert_tc_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tc_status[g]) |->
                (cur_count_flat[g*CUR_W +: CUR_W] ==
                 ({1'b0, base_flat[g*CNT_W +: CNT_W]} + CUR_W'(1))));
    end
endmodule

bind dma_svc_sched dma_svc_sched_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_disable   (ctrl_disable),
    .dreq           (dreq),
    .mask           (mask),
    .xfer_done      (xfer_done),
    .gnt_valid      (gnt_valid),
    .gnt_ch         (gnt_ch),
    .base_flat      (base_flat),
    .tc_status      (tc_status),
    .cur_count_flat (cur_count_flat)
);

// File: tb/dma_svc_sched_bench.sv
module dma_svc_sched_bench;
    localparam int N = 4;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_mode = 1'b0, ctrl_disable = 1'b0, rot_prio = 1'b0;
    logic [N-1:0] dreq = '0, mask = '0, tc_clr = '0, ch_load = '0;
    logic [N*6-1:0] mode_flat = '0;
    logic [N*CW-1:0] base_flat = '0;
    logic xfer_done = 1'b0;
    logic [CW+1:0] xfer_progress = '0;
    logic gnt_valid, gnt_mem_wr, gnt_mem_rd, gnt_autoinit, gnt_down;
    logic [1:0] gnt_ch;
    logic [CW+1:0] gnt_start, gnt_len;
    logic [N-1:0] tc_status;
    logic [N*(CW+1)-1:0] cur_count_flat;

    always #2 clk = ~clk;

    dma_svc_sched u_dma_svc_sched (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .ctrl_disable(ctrl_disable),
        .rot_prio(rot_prio), .dreq(dreq), .mask(mask), .tc_clr(tc_clr), .ch_load(ch_load),
        .mode_flat(mode_flat), .base_flat(base_flat), .xfer_done(xfer_done),
        .xfer_progress(xfer_progress), .gnt_valid(gnt_valid), .gnt_ch(gnt_ch),
        .gnt_start(gnt_start), .gnt_len(gnt_len), .gnt_mem_wr(gnt_mem_wr),
        .gnt_mem_rd(gnt_mem_rd), .gnt_autoinit(gnt_autoinit), .gnt_down(gnt_down),
        .tc_status(tc_status), .cur_count_flat(cur_count_flat)
    );

    typedef struct {
        int ch; int start; int len; int prog;
        bit wr; bit rd; bit ai; bit dn; int hold;
    } item_t;

    item_t q[$];
    int n_tests = 0, n_fail = 0, n_grants = 0;
    bit busy = 0, hold_req = 0;
    int m_cnt[N], m_base[N];
    bit m_tc[N];
    logic [5:0] m_mode[N];
    int w = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ch(input int ch, input int base, input logic [5:0] mode);
        m_base[ch] = base;
        m_mode[ch] = mode;
        base_flat[ch*CW +: CW] = CW'(base);
        mode_flat[ch*6 +: 6] = mode;
    endtask

    // Driver: computes the expected grant from the model and queues it
    task automatic push(input int ch, input int prog, input int hold);
        item_t it;
        it.ch = ch;
        it.start = m_cnt[ch] << w;
        it.len = (m_base[ch] + 1) << w;
        it.prog = prog;
        it.wr = (m_mode[ch][1:0] == 2'd1);
        it.rd = (m_mode[ch][1:0] == 2'd2);
        it.ai = m_mode[ch][2];
        it.dn = m_mode[ch][3];
        it.hold = hold;
        q.push_back(it);
        m_cnt[ch] = (prog >> w) & 32'h1FFFF;
        if (m_cnt[ch] == m_base[ch] + 1 && m_mode[ch][5:4] != 2'd3) m_tc[ch] = 1;
    endtask

    task automatic drain();
        do @(negedge clk); while (q.size() != 0 || busy);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_model(input string tag);
        for (int i = 0; i < N; i++) begin
            chk({tag, " count"}, longint'(cur_count_flat[i*(CW+1) +: CW+1]), longint'(m_cnt[i]));
            chk({tag, " tc flag"}, longint'(tc_status[i]), longint'(m_tc[i]));
        end
    endtask

    task automatic pulse_load(input int ch);
        @(negedge clk); ch_load[ch] = 1'b1;
        @(negedge clk); ch_load[ch] = 1'b0;
        m_cnt[ch] = 0;
    endtask

    // Monitor: pops expected items, compares, answers with done
    initial begin
        forever begin
            @(negedge clk);
            if (gnt_valid && !busy) begin
                item_t it;
                bit held_ok;
                busy = 1;
                n_grants++;
                if (q.size() == 0) begin
                    chk("R2 unexpected grant", 1, 0);
                    it.ch = int'(gnt_ch); it.start = int'(gnt_start); it.len = int'(gnt_len);
                    it.prog = int'(gnt_start); it.wr = gnt_mem_wr; it.rd = gnt_mem_rd;
                    it.ai = gnt_autoinit; it.dn = gnt_down; it.hold = 0;
                end else begin
                    it = q.pop_front();
                end
                chk("R4 R5 granted channel", longint'(gnt_ch), longint'(it.ch));
                chk("R6 start", longint'(gnt_start), longint'(it.start));
                chk("R6 length", longint'(gnt_len), longint'(it.len));
                chk("R11 mem write", longint'(gnt_mem_wr), longint'(it.wr));
                chk("R11 mem read", longint'(gnt_mem_rd), longint'(it.rd));
                chk("R11 autoinit/down", longint'({gnt_autoinit, gnt_down}), longint'({it.ai, it.dn}));
                if (!hold_req) dreq[gnt_ch] = 1'b0;
                else if (q.size() == 0) dreq = '0;
                held_ok = 1;
                for (int k = 0; k < it.hold; k++) begin
                    @(negedge clk);
                    if (!gnt_valid || int'(gnt_ch) != it.ch) held_ok = 0;
                end
                if (it.hold > 0) chk("R7 grant held", longint'(held_ok), 1);
                @(negedge clk);
                xfer_done = 1'b1;
                xfer_progress = (CW+2)'(it.prog);
                @(negedge clk);
                xfer_done = 1'b0;
                busy = 0;
            end
        end
    end

    task automatic final_report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        final_report();
    end

    initial begin
        int g0;
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_tc[i] = 0;
            set_ch(i, 100, 6'b01_0_0_01);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 no grant in reset", longint'(gnt_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 no grant after reset", longint'(gnt_valid), 0);
        check_model("R1 reset");

        // R9 R6: lone request reaches base+1
        set_ch(2, 9, 6'b01_0_0_01);
        push(2, 10, 0);
        dreq[2] = 1'b1;
        drain();
        check_model("R9 full count");

        // R8: partial count, then auto-init wrap below start
        set_ch(1, 9, 6'b01_0_0_01);
        push(1, 4, 0); dreq[1] = 1'b1; drain();
        check_model("R8 partial");
        set_ch(1, 9, 6'b01_1_0_01);
        push(1, 2, 0); dreq[1] = 1'b1; drain();
        check_model("R8 autoinit wrap");

        // R4: fixed order, channels 3 and 1 together
        set_ch(3, 20, 6'b01_0_0_01);
        push(1, 5, 0); push(3, 7, 0);
        dreq[3] = 1'b1; dreq[1] = 1'b1;
        drain();
        check_model("R4 fixed order");

        // R5: rotating priority with held requests, expect 0,1,2,0
        rot_prio = 1'b1; hold_req = 1;
        set_ch(0, 50, 6'b01_0_0_01); set_ch(1, 50, 6'b01_0_0_01); set_ch(2, 50, 6'b01_0_0_01);
        push(0, m_cnt[0] + 1, 0); push(1, m_cnt[1] + 1, 0);
        push(2, m_cnt[2] + 1, 0); push(0, m_cnt[0] + 1, 0);
        dreq = 4'b0111;
        drain();
        hold_req = 0; rot_prio = 1'b0;
        check_model("R5 rotation");

        // R3: disable holds off a request
        ctrl_disable = 1'b1; g0 = n_grants;
        dreq[0] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R3 no grant while disabled", longint'(n_grants - g0), 0);
        push(0, m_cnt[0] + 1, 0);
        ctrl_disable = 1'b0;
        drain();
        chk("R3 grant after enable", longint'(n_grants - g0), 1);

        // R2: masked request is not granted
        mask[3] = 1'b1; g0 = n_grants;
        dreq[3] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 masked channel idle", longint'(n_grants - g0), 0);
        push(3, m_cnt[3] + 1, 0);
        mask[3] = 1'b0;
        drain();
        chk("R2 grant after unmask", longint'(n_grants - g0), 1);

        // R12 R6: load to zero, then word mode doubles counts
        set_ch(0, 4, 6'b01_0_0_01);
        pulse_load(0);
        repeat (2) @(negedge clk);
        check_model("R12 load zero");
        word_mode = 1'b1; w = 1;
        push(0, 10, 0); dreq[0] = 1'b1; drain();
        check_model("R6 word mode");
        word_mode = 1'b0; w = 0;

        // R10: cascade reaching base+1 sets no flag
        set_ch(1, 3, 6'b11_0_0_01);
        pulse_load(1);
        push(1, 4, 0); dreq[1] = 1'b1; drain();
        check_model("R10 cascade");

        // R11: verify and read type decode
        set_ch(2, 50, 6'b01_1_1_00);
        push(2, m_cnt[2] + 1, 0); dreq[2] = 1'b1; drain();
        set_ch(3, 50, 6'b01_0_0_10);
        push(3, m_cnt[3] + 1, 0); dreq[3] = 1'b1; drain();
        check_model("R11 types");

        // R12: clear one flag only
        @(negedge clk); tc_clr[2] = 1'b1;
        @(negedge clk); tc_clr[2] = 1'b0;
        m_tc[2] = 0;
        @(negedge clk);
        check_model("R12 flag clear");

        // R7: grant held for several cycles while request drops
        push(3, m_cnt[3] + 2, 6); dreq[3] = 1'b1; drain();
        check_model("R7 after hold");

        final_report();
    end
endmodule